// File: doc/BRIEF.md
# Hibernation Wake Timer

A one-shot down-counter that measures sleep intervals in ticks of a 32.768 kHz always-on clock and raises a wake request when the interval ends. Software writes a 16-bit start value; the timer counts it down by one per tick, stops at zero, pulses a wake output for one bus clock and sets a sticky interrupt flag. A one-bit range select picks a short range (one count per slow-clock period, about 30.5 us, up to about 2 s) or a long range (one count per 4096 slow periods, 0.125 s, up to about 8192 s).

The block sits on a simple register bus in the system clock domain. The slow clock is brought across through a two-stage synchronizer, and each of its rising edges becomes a single-cycle tick. Only slow-clock edges advance the counter, so it keeps its pace however idle the bus side is. Software reads the remaining count at any time to work out how long the system slept. Writing zero as the start value disarms the timer.

Register map (word address on `bus_addr_i`): 0 = start value (read returns the last value written), 1 = range select in bit 0, 2 = live remaining count (read only), 3 = interrupt flag in bit 0 (write 1 to clear).

Top module: `hib_wake_timer`

## Requirements
- R1: After reset the live count, start value, range select and interrupt flag all read 0, and `irq_o` and `wake_o` are low.
- R2: In short range (bit 0 of address 1 = 0) the count drops by one for each rising edge of `slow_clk_i`; that edge reaches the count on the third bus clock edge that samples it high. A start value N expires after N slow edges.
- R3: In long range (bit 0 of address 1 = 1) the count drops by one only once every 4096 slow-clock rising edges.
- R4: Every write to address 0 restarts the 4096-edge prescale from zero, so the first long-range step after it takes a full 4096 slow edges.
- R5: Writing 0 to address 0 stops the timer: the count reads 0 and no expiry, wake pulse or flag follows.
- R6: Writing a nonzero value to address 0 loads it into the count and starts counting, also when the timer is already running.
- R7: Reads return the last start value at address 0, the range select in bit 0 of address 1, and the live remaining count at address 2, all without delay.
- R8: The interrupt flag (bit 0 of address 3) is set on expiry and stays set until a 1 is written to bit 0 of address 3; writing 0 leaves it alone, and an expiry in the same cycle as a clear leaves it set.
- R9: On expiry the count stops at 0 and stays there, and `wake_o` is high for exactly one clock cycle.
- R10: `irq_o` follows the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | 32.768 kHz always-on clock, asynchronous to clk |
| bus_addr_i | input | 2 | Register word address |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt, the sticky flag |
| wake_o | output | 1 | One-cycle wake request on expiry |

## Verification
Short-range runs with small start values show that each slow edge moves the count by exactly one and that expiry stops at zero instead of wrapping. Long-range runs measure the bus-clock distance between start and wake, which separates a 4096-edge prescale from a native-rate one; a restart three quarters of the way into a prescale window shows whether the prescaler is cleared by the write. A zero write during a run, a rewrite mid-run, and a clear held asserted across the expiry cycle separate disarm, restart and set-over-clear priority from one another.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 12;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_START = 2'd0,
    REG_RANGE = 2'd1,
    REG_LIVE  = 2'd2,
    REG_FLAG  = 2'd3
  } hwt_reg_e;

  // Next count value on a step: one lower, never below zero.
  function automatic logic [CNT_W-1:0] hwt_step(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // A step on a count of one ends the interval.
  function automatic logic hwt_last(input logic [CNT_W-1:0] c);
    return c == {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // Zero-extend a single status bit into a read word.
  function automatic logic [CNT_W-1:0] hwt_bit_word(input logic b);
    return {{(CNT_W-1){1'b0}}, b};
  endfunction
endpackage

// File: rtl/hwt_tick_sync.sv
module hwt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk_i,
  output logic slow_tick_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= slow_clk_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign slow_tick_o = chain_q[STAGES-1] & ~prev_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick_o |=> !slow_tick_o); // R2
endmodule

// File: rtl/hwt_prescale.sv
module hwt_prescale #(
  parameter int PRE_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic long_range_i,
  input  logic slow_tick_i,
  output logic step_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = slow_tick_i && (pre_q == PRE_MAX);
  assign step_o = long_range_i ? wrap : slow_tick_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          pre_q <= '0;
    else if (restart_i)                  pre_q <= '0;
    else if (long_range_i && slow_tick_i) pre_q <= pre_q + 1'b1;

  AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pre_q == '0)); // R4
  AST_LONG_STEP_RARE: assert property (@(posedge clk) disable iff (!rst_n)
    (long_range_i && step_o) |-> (pre_q == PRE_MAX)); // R3
endmodule

// File: rtl/hwt_counter.sv
module hwt_counter
  import hwt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             take_step;

  assign take_step = run_q && step_i && !load_i;
  assign expire_o  = take_step && hwt_last(cnt_q);
  assign count_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (take_step) begin
      cnt_q <= hwt_step(cnt_q);
      if (hwt_last(cnt_q)) run_q <= 1'b0;
    end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_step |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> $stable(cnt_q)); // R9
  AST_ZERO_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> !run_q); // R5
  AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (!expire_o && cnt_q == '0)); // R9
endmodule

// File: rtl/hib_wake_timer.sv
module hib_wake_timer
  import hwt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic             slow_tick;
  logic             cnt_step;
  logic             expire;
  logic [CNT_W-1:0] live_count;
  logic [CNT_W-1:0] start_q;
  logic             range_q;
  logic             flag_q;
  logic             wake_q;
  logic             wr_start, wr_range, wr_flag_clear;

  assign wr_start      = bus_wr_i && (bus_addr_i == REG_START);
  assign wr_range      = bus_wr_i && (bus_addr_i == REG_RANGE);
  assign wr_flag_clear = bus_wr_i && (bus_addr_i == REG_FLAG) && bus_wdata_i[0];

  hwt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_clk_i  (slow_clk_i),
    .slow_tick_o (slow_tick)
  );

  hwt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (wr_start),
    .long_range_i (range_q),
    .slow_tick_i  (slow_tick),
    .step_o       (cnt_step)
  );

  hwt_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_start),
    .load_val_i (bus_wdata_i),
    .step_i     (cnt_step),
    .count_o    (live_count),
    .expire_o   (expire)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= '0;
      range_q <= 1'b0;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      if (wr_start) start_q <= bus_wdata_i;
      if (wr_range) range_q <= bus_wdata_i[0];
      if (expire)             flag_q <= 1'b1;
      else if (wr_flag_clear) flag_q <= 1'b0;
      wake_q <= expire;
    end

  always_comb begin
    unique case (bus_addr_i)
      REG_START: bus_rdata_o = start_q;
      REG_RANGE: bus_rdata_o = hwt_bit_word(range_q);
      REG_LIVE:  bus_rdata_o = live_count;
      default:   bus_rdata_o = hwt_bit_word(flag_q);
    endcase
  end

  assign irq_o  = flag_q;
  assign wake_o = wake_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_flag_clear) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag_q && wake_o)); // R8
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o); // R9
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> wake_o); // R10
endmodule

// File: tb/hib_wake_timer_tb.sv
module hib_wake_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wake;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  localparam int HALF = 2;        // slow half-period in bus cycles
  localparam int PER  = 2 * HALF; // bus cycles per slow period

  always #2.5 clk = ~clk;         // 200 MHz

  hib_wake_timer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  initial forever begin
    repeat (HALF) @(negedge clk);
    #1 slow = ~slow;
  end

  // Behavioural reference model
  int h1, h2, h3;
  int m_cnt, m_start, m_pre;
  bit m_run, m_mode, m_flag, m_wake;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_cnt = 0; m_start = 0; m_pre = 0;
      m_run = 0; m_mode = 0; m_flag = 0; m_wake = 0;
    end else begin
      bit tick, step, ex;
      tick = (h2 == 1) && (h3 == 0);
      step = tick && (!m_mode || m_pre == 4095);
      ex = 0;
      if (wr && addr == 2'd0) begin
        m_cnt = wdata; m_start = wdata; m_run = (wdata != 0); m_pre = 0;
      end else begin
        if (m_mode && tick) m_pre = (m_pre + 1) % 4096;
        if (m_run && step) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_run = 0; ex = 1; end
        end
      end
      if (ex) m_flag = 1;
      else if (wr && addr == 2'd3 && wdata[0]) m_flag = 0;
      if (wr && addr == 2'd1) m_mode = wdata[0];
      m_wake = ex;
      h3 = h2; h2 = h1; h1 = int'(slow);
    end
  end

  function automatic int model_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_start;
      2'd1: return int'(m_mode);
      2'd2: return m_cnt;
      default: return int'(m_flag);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 read data vs model", int'(rdata), model_rd(addr));
    chk("R10 irq vs model", int'(irq), int'(m_flag));
    chk("R9 wake vs model", int'(wake), int'(m_wake));
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #1;
    wr = 1'b0; addr = 2'd2;
  endtask

  task automatic rd_expect(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); #1 addr = a;
    @(negedge clk); #0.5 chk(req, int'(rdata), exp);
    #0.5 addr = 2'd2;
  endtask

  task automatic wait_wake(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wake) begin at = cyc; break; end
    end
    if (at < 0) chk("R9 wake seen before limit", 0, 1);
  endtask

  initial begin
    int t0, t1, mid;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_expect(2'd0, 0, "R1 start after reset");
    rd_expect(2'd1, 0, "R1 range after reset");
    rd_expect(2'd2, 0, "R1 count after reset");
    rd_expect(2'd3, 0, "R1 flag after reset");
    chk("R1 irq after reset", int'(irq), 0);

    // R2 short range, N = 5
    bus_write(2'd0, 16'd5);
    rd_expect(2'd0, 5, "R7 start readback");
    repeat (2 * PER) @(negedge clk);
    @(negedge clk); #0.5 mid = int'(rdata);
    checks++;
    if (!(mid < 5 && mid > 0)) begin
      errors++; $display("FAIL R2 live count mid-run: actual=%0d expected=1..4", mid);
    end
    wait_wake(20 * PER, t1);
    @(negedge clk);
    chk("R9 wake one cycle", int'(wake), 0);
    rd_expect(2'd2, 0, "R9 count stays at zero");
    chk("R10 irq after expiry", int'(irq), 1);

    // R8 write 0 keeps the flag, write 1 clears it
    bus_write(2'd3, 16'd0);
    chk("R8 write 0 keeps flag", int'(irq), 1);
    bus_write(2'd3, 16'd1);
    chk("R8 write 1 clears flag", int'(irq), 0);

    // R5 zero start disarms
    bus_write(2'd0, 16'd7);
    repeat (2 * PER) @(negedge clk);
    bus_write(2'd0, 16'd0);
    repeat (20 * PER) @(negedge clk);
    rd_expect(2'd2, 0, "R5 count after zero write");
    chk("R5 no flag after disarm", int'(irq), 0);

    // R6 restart mid-run
    bus_write(2'd0, 16'd9);
    repeat (3 * PER) @(negedge clk);
    @(negedge clk); #1 addr = 2'd0; wdata = 16'd9; wr = 1'b1;
    @(negedge clk); #1 wr = 1'b0; addr = 2'd2;
    #0.5 chk("R6 reload value", int'(rdata), 9);
    wait_wake(20 * PER, t1);

    // R8 clear held across the expiry cycle
    bus_write(2'd0, 16'd2);
    @(negedge clk); #1 addr = 2'd3; wdata = 16'd1; wr = 1'b1;
    wait_wake(10 * PER, t1);
    chk("R8 set wins over clear", int'(irq), 1);
    #1 wr = 1'b0; addr = 2'd2;
    bus_write(2'd3, 16'd1);

    // R3 long range, N = 2
    bus_write(2'd1, 16'd1);
    rd_expect(2'd1, 1, "R7 range readback");
    t0 = cyc;
    bus_write(2'd0, 16'd2);
    repeat (3000 * PER) @(negedge clk);
    rd_expect(2'd2, 2, "R3 no step before 4096 edges");
    wait_wake(3 * 4096 * PER, t1);
    checks++;
    if ((t1 - t0) < 2 * 4096 * PER - 8 || (t1 - t0) > 2 * 4096 * PER + 8) begin
      errors++; $display("FAIL R3 long interval: actual=%0d expected=%0d+-8", t1 - t0, 2 * 4096 * PER);
    end
    bus_write(2'd3, 16'd1);

    // R4 restart clears the prescaler
    bus_write(2'd0, 16'd3);
    repeat (3000 * PER) @(negedge clk);
    t0 = cyc;
    bus_write(2'd0, 16'd1);
    wait_wake(2 * 4096 * PER, t1);
    checks++;
    if ((t1 - t0) < 4096 * PER - 8 || (t1 - t0) > 4096 * PER + 8) begin
      errors++; $display("FAIL R4 first long step: actual=%0d expected=%0d+-8", t1 - t0, 4096 * PER);
    end
    chk("R10 irq after long expiry", int'(irq), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule